// File: doc/BRIEF.md
# SPI Flash Generic Shift-Command Engine

This block sends one SPI flash command frame of arbitrary content and collects whatever the flash returns during it. Software fills six byte-wide outgoing registers, the opcode in the highest one and any argument bytes in the registers below it. It writes the number of bits to move into a length register and then sets a start bit in the command register. The engine lowers chip select and shifts the outgoing bits MSB-first on one data line in SPI mode 0. Each returned bit enters a six-byte capture chain. Chip select then rises and the start bit clears itself, so completion is found by polling the command register.

A second command value sends a one-byte status write: eight bits from the highest outgoing register, whatever the length register holds. Access is through a byte-wide register bus with a write strobe and a combinational read. The SCK half-period, in system clocks, is a parameter.

Top module: `nor_shift_top`

## Requirements
- R1: After reset the command register reads 0x00, chip select is high, SCK is low and every capture byte reads 0x00.
- R2: Writing a value with bit 2 set (0x04) to the command register (address 0x00) starts a frame of N bits, where N is the length register (address 0x01) clamped to 56.
- R3: Outgoing bits leave MSB-first from the outgoing register at address 0x0D (index 5), then 0x0C down to 0x08 (index 0). Any bits beyond the 48 held there are sent as 0.
- R4: The capture chain (index 0 at address 0x10 up to index 5 at 0x15) is cleared when a frame starts. Each sampled bit enters bit 0 of index 0, and the whole 48-bit chain shifts left, so after N bits it holds the last min(N,48) received bits right-aligned.
- R5: While a frame runs, the command register reads back the started command (0x04 or 0x20). It reads 0x00 from the cycle chip select rises.
- R6: Writing a value with bit 5 set (0x20) sends exactly 8 bits, taken from outgoing index 5, whatever the length register holds.
- R7: Chip select falls 2*HALF_DIV clocks before the first SCK rise and rises 2*HALF_DIV clocks after the last SCK fall. SCK is high for HALF_DIV clocks and low for HALF_DIV clocks per bit.
- R8: SCK idles low, MOSI changes only while SCK is low, and MISO is sampled at the end of each SCK high phase.
- R9: A write to the command register during a frame is ignored: the frame length and the command readback stay unchanged.
- R10: A generic start with an effective length of 0 sends no frame, and the command register reads 0x00 on the next cycle.
- R11: A command value with both bit 5 and bit 2 set runs as a status write of 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 5 | Register byte address |
| busWdata | input | 8 | Register write data |
| busRdata | output | 8 | Register read data (combinational) |
| spiCsN | output | 1 | Flash chip select, active low |
| spiSck | output | 1 | Serial clock, idles low |
| spiMosi | output | 1 | Serial data to flash |
| spiMiso | input | 1 | Serial data from flash |

## Verification
A wrong bit counter shows up at the end of the frame. The number of SCK pulses comes out wrong, and the command bit clears early or late, visible on the first poll after chip select rises. A corrupted outgoing or capture shift register shows at once in the MOSI stream seen by the bench's slave model, and in the capture bytes read back right after the frame. The bench sweeps every length from 0 to 60, which covers the clamp, the zero case and frames longer than the capture chain. A phase timer fault appears within one SCK period as a wrong lead, trail or high-phase width.

// File: rtl/nor_shift_pkg.sv
package nor_shift_pkg;

  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] ADDR_CMD = 5'h00;
  localparam logic [ADDR_W-1:0] ADDR_LEN = 5'h01;
  localparam logic [ADDR_W-1:0] ADDR_OUT = 5'h08;
  localparam logic [ADDR_W-1:0] ADDR_CAP = 5'h10;

  localparam logic [7:0] CMD_GENERIC = 8'h04;
  localparam logic [7:0] CMD_WSTAT   = 8'h20;
  localparam int         WSTAT_BITS  = 8;

  typedef struct packed {
    logic load;
    logic step;
  } dpStrobe_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LEAD,
    PH_HIGH,
    PH_LOW,
    PH_TRAIL
  } phase_t;

endpackage

// File: rtl/nor_shift_datapath.sv
module nor_shift_datapath
  import nor_shift_pkg::*;
#(
  parameter int BANK_BYTES = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  input  dpStrobe_t         strobe,
  input  logic              spiMiso,
  output logic              spiMosi,
  output logic [7:0]        dataRd
);

  localparam int CHAIN_W = 8 * BANK_BYTES;

  logic [7:0]         outReg [BANK_BYTES];
  logic [CHAIN_W-1:0] outFlat;
  logic [CHAIN_W-1:0] txShift;
  logic [CHAIN_W-1:0] capShift;

  for (genvar i = 0; i < BANK_BYTES; i++) begin : g_outReg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        outReg[i] <= '0;
      end else if (busWe && busAddr == ADDR_W'(ADDR_OUT + i)) begin
        outReg[i] <= busWdata;
      end
    end
    assign outFlat[i*8 +: 8] = outReg[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift  <= '0;
      capShift <= '0;
    end else if (strobe.load) begin
      txShift  <= outFlat;
      capShift <= '0;
    end else if (strobe.step) begin
      txShift  <= {txShift[CHAIN_W-2:0], 1'b0};
      capShift <= {capShift[CHAIN_W-2:0], spiMiso};
    end
  end

  assign spiMosi = txShift[CHAIN_W-1];

  always_comb begin
    dataRd = '0;
    for (int i = 0; i < BANK_BYTES; i++) begin
      if (busAddr == ADDR_W'(ADDR_OUT + i)) dataRd = outReg[i];
      if (busAddr == ADDR_W'(ADDR_CAP + i)) dataRd = capShift[i*8 +: 8];
    end
  end

  // R8: MOSI may move only on a load or a shift step
  p_mosi_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.load || strobe.step) |=> $stable(spiMosi));

  // R4: the capture chain starts every frame empty
  p_cap_cleared_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> capShift == '0);

endmodule

// File: rtl/nor_shift_control.sv
module nor_shift_control
  import nor_shift_pkg::*;
#(
  parameter int HALF_DIV = 4,
  parameter int MAX_BITS = 56
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        cmdRd,
  output logic [7:0]        lenRd,
  output dpStrobe_t         strobe,
  output logic              spiCsN,
  output logic              spiSck
);

  localparam int TMR_W = (2 * HALF_DIV > 1) ? $clog2(2 * HALF_DIV) : 1;
  localparam int BIT_W = $clog2(MAX_BITS + 1);
  localparam logic [TMR_W-1:0] HALF_END = TMR_W'(HALF_DIV - 1);
  localparam logic [TMR_W-1:0] FULL_END = TMR_W'(2 * HALF_DIV - 1);

  phase_t           phase;
  logic [TMR_W-1:0] timer;
  logic [BIT_W-1:0] bitsLeft;
  logic [BIT_W-1:0] reqBits;
  logic [7:0]       cmdReg;
  logic [7:0]       lenReg;
  logic             cmdWr;
  logic             wantStat;
  logic             wantGen;
  logic             startGo;

  assign cmdWr    = busWe && (busAddr == ADDR_CMD) && (phase == PH_IDLE);
  assign wantStat = busWdata[5];
  assign wantGen  = busWdata[2];

  always_comb begin
    if (wantStat) begin
      reqBits = BIT_W'(WSTAT_BITS);
    end else if (lenReg > 8'(MAX_BITS)) begin
      reqBits = BIT_W'(MAX_BITS);
    end else begin
      reqBits = BIT_W'(lenReg);
    end
  end

  assign startGo     = cmdWr && (wantStat || (wantGen && reqBits != '0));
  assign strobe.load = startGo;
  assign strobe.step = (phase == PH_HIGH) && (timer == HALF_END);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      timer    <= '0;
      bitsLeft <= '0;
      cmdReg   <= '0;
      lenReg   <= '0;
    end else begin
      if (busWe && busAddr == ADDR_LEN) lenReg <= busWdata;
      case (phase)
        PH_IDLE: begin
          if (startGo) begin
            phase    <= PH_LEAD;
            timer    <= '0;
            bitsLeft <= reqBits;
            cmdReg   <= wantStat ? CMD_WSTAT : CMD_GENERIC;
          end
        end
        PH_LEAD: begin
          if (timer == FULL_END) begin
            phase <= PH_HIGH;
            timer <= '0;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        PH_HIGH: begin
          if (timer == HALF_END) begin
            timer    <= '0;
            bitsLeft <= bitsLeft - 1'b1;
            phase    <= (bitsLeft == BIT_W'(1)) ? PH_TRAIL : PH_LOW;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        PH_LOW: begin
          if (timer == HALF_END) begin
            phase <= PH_HIGH;
            timer <= '0;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        PH_TRAIL: begin
          if (timer == FULL_END) begin
            phase  <= PH_IDLE;
            timer  <= '0;
            cmdReg <= '0;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign spiCsN = (phase == PH_IDLE);
  assign spiSck = (phase == PH_HIGH);
  assign cmdRd  = cmdReg;
  assign lenRd  = lenReg;

  // R2: the bit counter never exceeds the frame limit
  p_bits_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    bitsLeft <= BIT_W'(MAX_BITS));

  // R9: command writes inside the shifting phases leave the command untouched
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_HIGH || phase == PH_LOW) |=> $stable(cmdReg));

  // R5: the command bit is clear by the time chip select releases
  p_done_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(spiCsN) |-> cmdReg == 8'h00);

  // R5: a selected flash always has a command pending
  p_busy_shown_r5: assert property (@(posedge clk) disable iff (!rstN)
    !spiCsN |-> cmdReg != 8'h00);

endmodule

// File: rtl/nor_shift_top.sv
module nor_shift_top
  import nor_shift_pkg::*;
#(
  parameter int HALF_DIV        = 4,
  parameter int BANK_BYTES      = 6,
  parameter int MAX_FRAME_BYTES = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWe,
  input  logic [4:0] busAddr,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  output logic       spiCsN,
  output logic       spiSck,
  output logic       spiMosi,
  input  logic       spiMiso
);

  localparam int MAX_BITS = 8 * MAX_FRAME_BYTES;

  dpStrobe_t  strobe;
  logic [7:0] cmdRd;
  logic [7:0] lenRd;
  logic [7:0] dataRd;

  nor_shift_control #(
    .HALF_DIV (HALF_DIV),
    .MAX_BITS (MAX_BITS)
  ) u_control (
    .clk      (clk),
    .rstN     (rstN),
    .busWe    (busWe),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .cmdRd    (cmdRd),
    .lenRd    (lenRd),
    .strobe   (strobe),
    .spiCsN   (spiCsN),
    .spiSck   (spiSck)
  );

  nor_shift_datapath #(
    .BANK_BYTES (BANK_BYTES)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .busWe    (busWe),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .strobe   (strobe),
    .spiMiso  (spiMiso),
    .spiMosi  (spiMosi),
    .dataRd   (dataRd)
  );

  always_comb begin
    if (busAddr == ADDR_CMD)      busRdata = cmdRd;
    else if (busAddr == ADDR_LEN) busRdata = lenRd;
    else                          busRdata = dataRd;
  end

endmodule

// File: tb/nor_shift_top_test.sv
`timescale 1ns/1ps
module nor_shift_top_test;

  localparam int HALF = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWe = 1'b0;
  logic [4:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       spiCsN, spiSck, spiMosi;
  logic       spiMiso = 1'b0;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  nor_shift_top #(.HALF_DIV(HALF)) uut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .spiCsN(spiCsN),
    .spiSck(spiSck), .spiMosi(spiMosi), .spiMiso(spiMiso)
  );

  // slave model and monitor, all at the falling system clock edge
  logic [55:0] sPat = '0;
  logic [63:0] mosiBits;
  int          nBits, sIdx, cycNo = 0, frames = 0;
  int          tCsFall, tFirstRise, tLastFall, tCsRise, badHigh;
  logic        prevCs = 1'b1, prevSck = 1'b0, prevMosi = 1'b0, seenRise;

  always @(negedge clk) begin
    cycNo++;
    if (prevCs && !spiCsN) begin
      frames++;
      tCsFall = cycNo; nBits = 0; mosiBits = '0; seenRise = 1'b0;
      badHigh = 0; sIdx = 0; spiMiso = sPat[55];
    end
    if (!prevSck && spiSck) begin
      if (!seenRise) tFirstRise = cycNo;
      seenRise = 1'b1;
      mosiBits = {mosiBits[62:0], spiMosi};
      nBits++;
    end
    if (prevSck && spiSck && spiMosi != prevMosi) badHigh++;
    if (spiCsN && spiSck) badHigh++;
    if (prevSck && !spiSck) begin
      tLastFall = cycNo;
      sIdx++;
      spiMiso = (sIdx < 56) ? sPat[55 - sIdx] : 1'b0;
    end
    if (!prevCs && spiCsN) tCsRise = cycNo;
    prevCs = spiCsN; prevSck = spiSck; prevMosi = spiMosi;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic waitIdle();
    logic [7:0] v;
    for (int k = 0; k < 3000; k++) begin
      busRead(5'h00, v);
      if (v == 8'h00) break;
    end
    repeat (2) @(negedge clk);
  endtask

  // run one frame and check it against the arithmetic model
  task automatic runFrame(input logic [7:0] cmdVal, input logic [7:0] lenVal,
                          input int n, input int seed, input string req);
    logic [7:0]  pd [6];
    logic [55:0] full;
    logic [63:0] expM, expCap;
    logic [7:0]  v;
    for (int k = 0; k < 6; k++) begin
      pd[k] = 8'(seed * 37 + k * 53 + 11);
      busWrite(5'(8 + k), pd[k]);
    end
    for (int k = 0; k < 7; k++) sPat[8*k +: 8] = 8'(seed * 29 + k * 71 + 5);
    busWrite(5'h01, lenVal);
    busWrite(5'h00, cmdVal);
    busRead(5'h00, v);
    chk(v == (cmdVal[5] ? 8'h20 : 8'h04), {req, " R5 busy readback"}, 64'(v), 64'(cmdVal[5] ? 8'h20 : 8'h04));
    waitIdle();
    busRead(5'h00, v);
    chk(v == 8'h00, {req, " R5 cleared"}, 64'(v), 0);
    chk(nBits == n, {req, " R2 bit count"}, 64'(nBits), 64'(n));
    full = '0;
    for (int k = 0; k < 6; k++) full[55 - 8*k -: 8] = pd[5 - k];
    expM = 64'(full) >> (56 - n);
    chk(mosiBits == expM, {req, " R3 mosi stream"}, mosiBits, expM);
    expCap = (64'(sPat) >> (56 - n)) & 64'hFFFF_FFFF_FFFF;
    for (int k = 0; k < 6; k++) begin
      busRead(5'(16 + k), v);
      chk(v == expCap[8*k +: 8], {req, " R4 capture byte"}, 64'(v), 64'(expCap[8*k +: 8]));
    end
    chk(tFirstRise - tCsFall == 2*HALF, {req, " R7 lead"}, 64'(tFirstRise - tCsFall), 64'(2*HALF));
    chk(tCsRise - tLastFall == 2*HALF, {req, " R7 trail"}, 64'(tCsRise - tLastFall), 64'(2*HALF));
    chk(badHigh == 0, {req, " R8 mosi moved while sck high"}, 64'(badHigh), 0);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [7:0] v;
    int f0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    busRead(5'h00, v);
    chk(v == 8'h00, "R1 command reg", 64'(v), 0);
    chk(spiCsN == 1'b1, "R1 chip select", 64'(spiCsN), 1);
    chk(spiSck == 1'b0, "R1 sck", 64'(spiSck), 0);
    for (int k = 0; k < 6; k++) begin
      busRead(5'(16 + k), v);
      chk(v == 8'h00, "R1 capture", 64'(v), 0);
    end

    // R10: zero length starts nothing
    f0 = frames;
    busWrite(5'h01, 8'd0);
    busWrite(5'h00, 8'h04);
    busRead(5'h00, v);
    chk(v == 8'h00, "R10 command after zero length", 64'(v), 0);
    repeat (20) @(negedge clk);
    chk(frames == f0, "R10 no frame", 64'(frames - f0), 0);

    // R2 R3 R4 R7 R8: sweep every length, with clamp past 56
    for (int n = 1; n <= 60; n++) begin
      runFrame(8'h04, 8'(n), (n > 56) ? 56 : n, n, "R2 sweep");
    end

    // R6: status write ignores the length register
    runFrame(8'h20, 8'd40, 8, 91, "R6 status write");
    // R11: both bits set behaves as status write
    runFrame(8'h24, 8'd24, 8, 92, "R11 both bits");

    // R9: a command write mid-frame is ignored
    busWrite(5'h01, 8'd16);
    busWrite(5'h00, 8'h04);
    repeat (10) @(negedge clk);
    busWrite(5'h00, 8'h20);
    busRead(5'h00, v);
    chk(v == 8'h04, "R9 command readback kept", 64'(v), 4);
    waitIdle();
    chk(nBits == 16, "R9 frame length kept", 64'(nBits), 16);

    finishRun();
  end

endmodule